// File: doc/BRIEF.md
# Tag-Steered Receive Queue Demultiplexer

This block sits between a tile's network receive port and its processor. Each arriving message starts with a header word that gives the number of body words. The next word is a tag that names the sender, the stream and the message kind. The block compares that tag with a small set of programmable match entries, one per demux queue. It then writes the tag and every body word of the message into the queue whose entry matched. A tag that matches no valid entry sends the message to a catch-all queue. That queue raises an interrupt request until software has drained it.

A fixed pool of receive storage is divided equally among the demux queues and the catch-all queue. Each queue gets the largest power-of-two share that fits. When the queue a message is headed for fills up, the block stops taking network words until space frees, so no word is ever lost. The processor pops words by naming a queue. A pop from an empty queue is answered with not-ready and leaves all state as it was. Every queue shows its empty flag and its word count.

Top module: `rxd_tag_demux`

## Requirements
- R1: The low 8 bits of a header word give N, the number of body words. The word after the header is the tag. The queue choice made on the tag holds for exactly N further words, and the word after those is taken as a new header. N may be 0.
- R2: A tag equal to a valid match entry i sends the tag and then the N body words, in arrival order, into demux queue i.
- R3: A match entry whose valid bit is clear never matches, even when its stored tag equals the incoming tag.
- R4: A tag that matches no valid entry sends the message to the catch-all queue, whose index is the number of demux queues (4 by default), and raises `irq`.
- R5: `irq` is high in every cycle in which the catch-all queue holds at least one word, and low once it is empty.
- R6: When more than one valid entry matches, the entry with the lowest index wins.
- R7: While the target queue of the current tag or body word is full, `in_ready` is low and the word is held. It is accepted once space frees. No word is dropped or reordered. `in_ready` is always high when a header is expected.
- R8: A pop request (`rd_req`) naming an empty queue, or an index above the catch-all index, gets `rd_ready` low and changes no count.
- R9: After reset every queue is empty with count 0, `irq` is low and `in_ready` is high.
- R10: Each queue holds the largest power of two not above 128 divided by the queue count. This is 16 words with the default 4+1 queues.
- R11: `q_count` holds one 5-bit count per queue (queue q at bits [5q+4:5q]), and `q_empty` bit q is high exactly when that count is 0. A count rises by one for each word stored and falls by one for each accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a tag match entry |
| cfg_idx | input | 3 | Index of the match entry to write |
| cfg_tag | input | 32 | Tag value to store |
| cfg_en | input | 1 | Valid bit to store with the tag |
| in_valid | input | 1 | Network word present |
| in_data | input | 32 | Network word |
| in_ready | output | 1 | Network word accepted this cycle when high with in_valid |
| rd_req | input | 1 | Processor pop request |
| rd_sel | input | 3 | Queue to pop from (4 is the catch-all queue) |
| rd_ready | output | 1 | Pop accepted, rd_data valid |
| rd_data | output | 32 | Head word of the selected queue |
| q_empty | output | 5 | Per-queue empty flags |
| q_count | output | 25 | Per-queue word counts, 5 bits each |
| irq | output | 1 | Catch-all queue non-empty |

## Verification
The assertions assume that the network side keeps a word and its valid stable while `in_ready` is low. They also assume that configuration writes do not land in the same cycle as a tag word they would change. The bench sets `in_valid` and `in_data` on the falling edge and leaves them there until a rising edge finds `in_ready` high. It programs all match entries while no message is in flight. Header lengths are kept at or below the queue depth plus a few words, so that the stall case is reached by a controlled pop rather than by a deadlock.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_TAG  = 2'd1,
    ST_BODY = 2'd2
  } rx_state_e;

  // largest power of two that does not exceed v (v >= 1)
  function automatic int floor_pow2(input int v);
    int p;
    p = 1;
    for (int i = 1; i < 31; i++) begin
      if ((1 << i) <= v) p = 1 << i;
    end
    return p;
  endfunction

  // equal power-of-two share of the pool for each queue
  function automatic int share_depth(input int total, input int nq);
    return floor_pow2(total / nq);
  endfunction

  // width of a queue index covering demux queues plus catch-all
  function automatic int qsel_w(input int num_dq);
    return (num_dq + 1 > 1) ? $clog2(num_dq + 1) : 1;
  endfunction

  // width of a per-queue occupancy counter
  function automatic int cnt_w(input int total, input int num_dq);
    return $clog2(share_depth(total, num_dq + 1) + 1);
  endfunction

endpackage

// File: rtl/rxd_tag_match.sv
module rxd_tag_match #(
  parameter int NUM_DQ = 4,
  parameter int DW     = 32,
  parameter int QW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_idx,
  input  logic [DW-1:0] cfg_tag,
  input  logic          cfg_en,
  input  logic [DW-1:0] probe_tag,
  output logic          hit_any,
  output logic [QW-1:0] hit_idx
);
  localparam int NQ = NUM_DQ + 1;

  logic [DW-1:0] ent_tag [NQ];
  logic [NQ-1:0] ent_en;
  logic [NQ-1:0] match_vec;

  // slot NUM_DQ stands for the catch-all queue and never holds an entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_en <= '0;
      for (int i = 0; i < NQ; i++) ent_tag[i] <= '0;
    end else if (cfg_we && (int'(cfg_idx) < NUM_DQ)) begin
      ent_tag[cfg_idx] <= cfg_tag;
      ent_en[cfg_idx]  <= cfg_en;
    end
  end

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_cmp
      if (g < NUM_DQ) begin : g_live
        assign match_vec[g] = ent_en[g] && (ent_tag[g] == probe_tag);
      end else begin : g_none
        assign match_vec[g] = 1'b0;
      end
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = QW'(i);
    end
  end
  assign hit_any = |match_vec;

  p_valid_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (ent_en[hit_idx] && ent_tag[hit_idx] == probe_tag));

  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((match_vec & ((NQ'(1) << hit_idx) - NQ'(1))) == '0));

endmodule

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= push_data_i;
        wr_ptr      <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_i) begin
        rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
      end
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem[rd_ptr];
  assign empty_o = (cnt_o == '0);
  assign full_o  = (int'(cnt_o) == DEPTH);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_o == $past(cnt_o) + CW'($past(push_i)) - CW'($past(pop_i))));

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_o) <= DEPTH);

endmodule

// File: rtl/rxd_steer.sv
module rxd_steer
  import rxd_pkg::*;
#(
  parameter int NUM_DQ = 4,
  parameter int DW     = 32,
  parameter int QW     = 3,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  input  logic              hit_any,
  input  logic [QW-1:0]     hit_idx,
  input  logic [NUM_DQ:0]   q_full,
  output logic [NUM_DQ:0]   q_push,
  output logic              word_fire
);
  localparam int NQ = NUM_DQ + 1;
  localparam logic [QW-1:0] CA_IDX = QW'(NUM_DQ);

  rx_state_e        st;
  logic [LEN_W-1:0] remaining;
  logic [QW-1:0]    sel;
  logic [QW-1:0]    tgt;

  always_comb begin
    tgt = sel;
    if (st == ST_TAG) tgt = hit_any ? hit_idx : CA_IDX;
  end

  assign in_ready  = (st == ST_HDR) ? 1'b1 : !q_full[tgt];
  assign word_fire = in_valid && in_ready;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_push
      assign q_push[g] = word_fire && (st != ST_HDR) && (tgt == QW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      remaining <= '0;
      sel       <= '0;
    end else if (word_fire) begin
      unique case (st)
        ST_HDR: begin
          remaining <= in_data[LEN_W-1:0];
          st        <= ST_TAG;
        end
        ST_TAG: begin
          sel <= tgt;
          st  <= (remaining == '0) ? ST_HDR : ST_BODY;
        end
        ST_BODY: begin
          remaining <= remaining - 1'b1;
          if (remaining == LEN_W'(1)) st <= ST_HDR;
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  p_hold_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY && $past(st) == ST_BODY) |-> $stable(sel));

  p_hdr_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (st != ST_HDR));

  p_one_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_push));

endmodule

// File: rtl/rxd_tag_demux.sv
module rxd_tag_demux
  import rxd_pkg::*;
#(
  parameter int NUM_DQ      = 4,
  parameter int DW          = 32,
  parameter int POOL_WORDS  = 128,
  parameter int LEN_W       = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_we,
  input  logic [qsel_w(NUM_DQ)-1:0]                     cfg_idx,
  input  logic [DW-1:0]                                 cfg_tag,
  input  logic                                          cfg_en,
  input  logic                                          in_valid,
  input  logic [DW-1:0]                                 in_data,
  output logic                                          in_ready,
  input  logic                                          rd_req,
  input  logic [qsel_w(NUM_DQ)-1:0]                     rd_sel,
  output logic                                          rd_ready,
  output logic [DW-1:0]                                 rd_data,
  output logic [NUM_DQ:0]                               q_empty,
  output logic [(NUM_DQ+1)*cnt_w(POOL_WORDS,NUM_DQ)-1:0] q_count,
  output logic                                          irq
);
  localparam int NQ    = NUM_DQ + 1;
  localparam int QW    = qsel_w(NUM_DQ);
  localparam int DEPTH = share_depth(POOL_WORDS, NQ);
  localparam int CW    = cnt_w(POOL_WORDS, NUM_DQ);

  logic          hit_any;
  logic [QW-1:0] hit_idx;
  logic [NQ-1:0] q_full;
  logic [NQ-1:0] q_push;
  logic [NQ-1:0] q_pop;
  logic [DW-1:0] q_head [NQ];
  logic          word_fire;
  logic          sel_ok;
  logic          ca_push;

  rxd_tag_match #(.NUM_DQ(NUM_DQ), .DW(DW), .QW(QW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag), .cfg_en(cfg_en),
    .probe_tag(in_data), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  rxd_steer #(.NUM_DQ(NUM_DQ), .DW(DW), .QW(QW), .LEN_W(LEN_W)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .hit_any(hit_any), .hit_idx(hit_idx),
    .q_full(q_full), .q_push(q_push), .word_fire(word_fire)
  );

  assign sel_ok   = (int'(rd_sel) < NQ);
  assign rd_ready = rd_req && sel_ok && !q_empty[rd_sel];
  assign rd_data  = sel_ok ? q_head[rd_sel] : '0;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      logic [CW-1:0] cnt;
      assign q_pop[g] = rd_ready && (rd_sel == QW'(g));
      rxd_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(q_push[g]), .push_data_i(in_data),
        .pop_i(q_pop[g]), .head_o(q_head[g]),
        .full_o(q_full[g]), .empty_o(q_empty[g]), .cnt_o(cnt)
      );
      assign q_count[g*CW +: CW] = cnt;
    end
  endgenerate

  assign ca_push = q_push[NUM_DQ];
  assign irq     = !q_empty[NUM_DQ];

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ca_push));

  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(q_pop[NUM_DQ]));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (q_count == $past(q_count) || $past(word_fire)));

endmodule

// File: tb/sim_rxd_tag_demux.sv
module sim_rxd_tag_demux;
  localparam int NDQ = 4;
  localparam int NQ  = NDQ + 1;
  localparam int CW  = 5;
  localparam int DEP = 16;  // largest power of two <= 128/5

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [31:0]   cfg_tag = '0;
  logic          cfg_en = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_ready;
  logic          rd_req = 1'b0;
  logic [2:0]    rd_sel = '0;
  logic          rd_ready;
  logic [31:0]   rd_data;
  logic [NQ-1:0] q_empty;
  logic [NQ*CW-1:0] q_count;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxd_tag_demux u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag), .cfg_en(cfg_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data),
    .q_empty(q_empty), .q_count(q_count), .irq(irq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int cnt_of(input int q);
    return int'(q_count[q*CW +: CW]);
  endfunction

  task automatic program_entry(input int idx, input logic [31:0] tag, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_tag = tag; cfg_en = en;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    forever begin
      #2;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic pop(input int q, output logic ok, output logic [31:0] d);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 3'(q);
    #2 ok = rd_ready; d = rd_data;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic send_msg(input logic [31:0] tag, input int n, input logic [31:0] base);
    send(32'(n));
    send(tag);
    for (int i = 0; i < n; i++) send(base + 32'(i));
  endtask

  task automatic drain_expect(input string req, input int q, input logic [31:0] tag,
                              input int n, input logic [31:0] base);
    logic ok; logic [31:0] d;
    pop(q, ok, d);
    check(req, "tag pop ready", ok, 1);
    check(req, "tag word", d, tag);
    for (int i = 0; i < n; i++) begin
      pop(q, ok, d);
      check(req, "body pop ready", ok, 1);
      check(req, "body word", d, base + 32'(i));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9", "in_ready", in_ready, 1);
    check("R9", "irq", irq, 0);
    check("R9", "q_empty", q_empty, 5'h1f);
    check("R9", "q_count", q_count, 0);
  endtask

  task automatic t_match();
    send_msg(32'h0000_0200, 3, 32'hA000);
    @(negedge clk);
    check("R2", "queue1 count", cnt_of(1), 4);
    check("R11", "queue1 not empty", q_empty[1], 0);
    check("R2", "other queues empty", {q_empty[4], q_empty[3], q_empty[2], q_empty[0]}, 4'hf);
    drain_expect("R2", 1, 32'h0000_0200, 3, 32'hA000);
    @(negedge clk);
    check("R11", "queue1 drained", q_empty[1], 1);
  endtask

  task automatic t_zero_len();
    send_msg(32'h0000_0100, 0, 32'h0);
    send_msg(32'h0000_0100, 1, 32'hC000);
    @(negedge clk);
    check("R1", "queue0 count after N=0 then N=1", cnt_of(0), 3);
    drain_expect("R1", 0, 32'h0000_0100, 0, 32'h0);
    drain_expect("R1", 0, 32'h0000_0100, 1, 32'hC000);
  endtask

  task automatic t_priority();
    send_msg(32'h0000_0555, 2, 32'hD000);
    @(negedge clk);
    check("R6", "lowest matching queue2 count", cnt_of(2), 3);
    check("R6", "queue3 untouched", cnt_of(3), 0);
    drain_expect("R6", 2, 32'h0000_0555, 2, 32'hD000);
  endtask

  task automatic t_miss();
    send_msg(32'h0000_0300, 2, 32'hE000);  // entry 3 holds 0x300 but is invalid
    @(negedge clk);
    check("R3", "invalid entry queue3 count", cnt_of(3), 0);
    check("R4", "catch-all count", cnt_of(4), 3);
    check("R4", "irq raised", irq, 1);
    drain_expect("R4", 4, 32'h0000_0300, 1, 32'hE000);
    @(negedge clk);
    check("R5", "irq still high with one word", irq, 1);
    drain_expect("R5", 4, 32'hE001, 0, 32'h0);
    @(negedge clk);
    check("R5", "irq low once empty", irq, 0);
  endtask

  task automatic t_backpressure();
    logic ok; logic [31:0] d;
    send(32'd16);
    send(32'h0000_0100);
    for (int i = 0; i < 15; i++) send(32'hB000 + 32'(i));
    @(negedge clk);
    check("R10", "queue0 full at depth", cnt_of(0), DEP);
    in_valid = 1'b1; in_data = 32'hB00F;
    #2 check("R7", "ready low when full", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    #2 check("R7", "ready still low", in_ready, 0);
    check("R7", "count held", cnt_of(0), DEP);
    pop(0, ok, d);
    check("R7", "tag popped", d, 32'h0000_0100);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R7", "held word stored", cnt_of(0), DEP);
    for (int i = 0; i < 16; i++) begin
      pop(0, ok, d);
      check("R7", "no drop order", d, 32'hB000 + 32'(i));
    end
    @(negedge clk);
    check("R1", "new header accepted after body", in_ready, 1);
  endtask

  task automatic t_empty_read();
    logic ok; logic [31:0] d;
    pop(3, ok, d);
    check("R8", "empty pop not ready", ok, 0);
    @(negedge clk);
    check("R8", "counts unchanged", q_count, 0);
    pop(6, ok, d);
    check("R8", "bad index not ready", ok, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    program_entry(0, 32'h0000_0100, 1'b1);
    program_entry(1, 32'h0000_0200, 1'b1);
    program_entry(2, 32'h0000_0555, 1'b1);
    program_entry(3, 32'h0000_0555, 1'b1);
    t_priority();
    program_entry(3, 32'h0000_0300, 1'b0);
    t_match();
    t_zero_len();
    t_miss();
    t_backpressure();
    t_empty_read();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule